// File: doc/BRIEF.md
# Narrow Flash Fetch Adapter

This block connects a processor's instruction-fetch and data-read request lines to a flash array whose read port is only 16 bits wide. A 32-bit instruction word or data word is built from two consecutive half-word reads, with the even half-word read first. A 16-bit instruction or data item needs one read. Every data access starts with one address-decode dead cycle in which the array is not read. A multiple-word load walks consecutive words, and each word has its own dead cycle and its own pair of reads.

Requesters hold their request line high until they see the ready pulse. Data requests win over instruction fetches. After the last word of a data access, one idle cycle passes before a fetch can be accepted. The array is a synchronous memory: the read data for the half-word address driven in one cycle appears on the read-data input in the next cycle.

Top module: `flash_fetch_adapter`

## Requirements
- R1: After reset, `respReady` and `flashRd` are low and stay low while no request is raised.
- R2: A 32-bit fetch (`fetchHalf`=0) reads half-word index {addr[15:2],0} and then {addr[15:2],1}, with no dead cycle. `respReady` comes in the 3rd cycle after the accepting edge, and `respData` = {upper half, lower half}: the even half-word fills bits 15:0.
- R3: A 16-bit fetch (`fetchHalf`=1) makes one read at half-word index addr[15:1]. `respReady` comes in the 2nd cycle after acceptance, and `respData` bits 31:16 are zero.
- R4: A 32-bit data read spends one cycle with `flashRd` low right after acceptance, then makes two reads. `respReady` comes in the 4th cycle.
- R5: A 16-bit data read (`dataHalf`=1) spends one dead cycle and then makes one read. `respReady` comes in the 3rd cycle, `respData`[31:16] is zero, and `dataCount` has no effect: exactly one ready pulse is produced.
- R6: A word data read with `dataCount`=N (2..16) returns N words from consecutive word addresses. It makes 2N reads, and a ready pulse comes every 4 cycles. `dataCount` of 0 or 1 means one word.
- R7: `respReady` stays low from acceptance until the final half-word is on the array output, and it is high for exactly one cycle for each returned item.
- R8: When both requests are pending in an idle cycle, the data access is served first.
- R9: After the final data word's ready cycle, one further cycle passes before a fetch is accepted. A fetch held high after another fetch's ready is accepted in the next cycle.
- R10: `respIsData` is 1 with the ready pulse of a data access and 0 with that of a fetch.
- R11: Byte-address bits below the access width are ignored: addr[1:0] for 32-bit accesses and addr[0] for 16-bit accesses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fetchReq | input | 1 | Instruction fetch request, held until ready |
| fetchAddr | input | 16 | Fetch byte address |
| fetchHalf | input | 1 | 1 = 16-bit instruction mode, 0 = 32-bit |
| dataReq | input | 1 | Data read request, held until the last ready |
| dataAddr | input | 16 | Data byte address |
| dataHalf | input | 1 | 1 = 16-bit data read, 0 = word read |
| dataCount | input | 5 | Number of words for a word read (0/1 = single) |
| flashRd | output | 1 | Array read enable |
| flashAddr | output | 15 | Array half-word index |
| flashRdata | input | 16 | Array read data, one cycle after the read |
| respReady | output | 1 | One-cycle pulse: respData valid |
| respIsData | output | 1 | Source of the current response (1 = data) |
| respData | output | 32 | Assembled response |

## Verification
Counting from the edge that accepts a request, the ready pulse is due in cycle 2 for a 16-bit fetch, cycle 3 for a 32-bit fetch or a 16-bit data read, and cycle 4 for a data word. Each further word of a multiple load follows 4 cycles later. A fetch that waits behind a data word is ready 5 cycles after that word's pulse, and a chained fetch 3 cycles after the previous fetch's pulse. The bench raises requests on a falling edge and counts falling edges until it sees ready. It checks that count exactly, together with the number of read cycles seen and whether the first cycle had a read, so an early, late or extra pulse is reported. Response data is compared against a half-word pattern computed from the address.

// File: rtl/flash_adapter_pkg.sv
package flash_adapter_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEAD,
    ST_RDLO,
    ST_RDHI,
    ST_DONE,
    ST_GAP
  } adState_t;

  typedef struct packed {
    logic loadFetch;
    logic loadData;
    logic stepAddr;
    logic captureLo;
    logic wideWord;
  } adStrobe_t;

endpackage

// File: rtl/flash_adapter_ctrl.sv
module flash_adapter_ctrl
  import flash_adapter_pkg::*;
#(
  parameter int MAX_BURST = 16,
  parameter int CNT_W     = $clog2(MAX_BURST + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fetchReq,
  input  logic             fetchHalf,
  input  logic             dataReq,
  input  logic             dataHalf,
  input  logic [CNT_W-1:0] dataCount,
  output adStrobe_t        strobe,
  output logic             flashRd,
  output logic             respReady,
  output logic             respIsData
);

  adState_t         state, stateNext;
  logic [CNT_W-1:0] wordsLeft;
  logic [CNT_W-1:0] burstLen;
  logic             wideReg;
  logic             isDataReg;
  logic             acceptData;
  logic             acceptFetch;
  logic             moreWords;

  // data wins; data may also start in the gap cycle, a fetch may not
  assign acceptData  = dataReq && (state == ST_IDLE || state == ST_GAP);
  assign acceptFetch = fetchReq && !dataReq && (state == ST_IDLE);
  assign moreWords   = wordsLeft > CNT_W'(1);

  always_comb begin
    if (dataHalf || dataCount == '0)
      burstLen = CNT_W'(1);
    else if (int'(dataCount) > MAX_BURST)
      burstLen = CNT_W'(MAX_BURST);
    else
      burstLen = dataCount;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE, ST_GAP: begin
        if (acceptData)       stateNext = ST_DEAD;
        else if (acceptFetch) stateNext = fetchHalf ? ST_RDHI : ST_RDLO;
        else                  stateNext = ST_IDLE;
      end
      ST_DEAD: stateNext = wideReg ? ST_RDLO : ST_RDHI;
      ST_RDLO: stateNext = ST_RDHI;
      ST_RDHI: stateNext = ST_DONE;
      ST_DONE: begin
        if (moreWords)      stateNext = ST_DEAD;
        else if (isDataReg) stateNext = ST_GAP;
        else                stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      wordsLeft <= CNT_W'(1);
      wideReg   <= 1'b0;
      isDataReg <= 1'b0;
    end else begin
      state <= stateNext;
      if (acceptData) begin
        wideReg   <= !dataHalf;
        isDataReg <= 1'b1;
        wordsLeft <= burstLen;
      end else if (acceptFetch) begin
        wideReg   <= !fetchHalf;
        isDataReg <= 1'b0;
        wordsLeft <= CNT_W'(1);
      end else if (state == ST_DONE && moreWords) begin
        wordsLeft <= wordsLeft - CNT_W'(1);
      end
    end
  end

  always_comb begin
    strobe.loadFetch = acceptFetch;
    strobe.loadData  = acceptData;
    strobe.stepAddr  = (state == ST_RDLO) || (state == ST_DONE && moreWords);
    strobe.captureLo = (state == ST_RDHI) && wideReg;
    strobe.wideWord  = wideReg;
  end

  assign flashRd    = (state == ST_RDLO) || (state == ST_RDHI);
  assign respReady  = (state == ST_DONE);
  assign respIsData = isDataReg;

  // R7
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    respReady |=> !respReady);

  // R7
  ready_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    respReady |-> $past(flashRd));

  // R4
  dead_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    acceptData |=> !flashRd);

  // R9
  fetch_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (respReady && respIsData && !moreWords) |=> !acceptFetch);

  // R8
  data_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataReq && fetchReq && state == ST_IDLE) |=> respIsData);

endmodule

// File: rtl/flash_adapter_datapath.sv
module flash_adapter_datapath
  import flash_adapter_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int HALF_W = 16,
  parameter int IDX_W  = ADDR_W - 1,
  parameter int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  adStrobe_t         strobe,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              fetchHalf,
  input  logic [ADDR_W-1:0] dataAddr,
  input  logic              dataHalf,
  input  logic [HALF_W-1:0] flashRdata,
  output logic [IDX_W-1:0]  flashAddr,
  output logic [WORD_W-1:0] respData
);

  logic [IDX_W-1:0]  idxReg;
  logic [HALF_W-1:0] loReg;
  logic [IDX_W-1:0]  fetchIdx;
  logic [IDX_W-1:0]  dataIdx;

  // wide accesses start on the even half-word of the word
  assign fetchIdx = fetchHalf ? fetchAddr[ADDR_W-1:1] : {fetchAddr[ADDR_W-1:2], 1'b0};
  assign dataIdx  = dataHalf  ? dataAddr[ADDR_W-1:1]  : {dataAddr[ADDR_W-1:2], 1'b0};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxReg <= '0;
      loReg  <= '0;
    end else begin
      if (strobe.loadData)       idxReg <= dataIdx;
      else if (strobe.loadFetch) idxReg <= fetchIdx;
      else if (strobe.stepAddr)  idxReg <= idxReg + IDX_W'(1);
      if (strobe.captureLo)      loReg  <= flashRdata;
    end
  end

  assign flashAddr = idxReg;
  assign respData  = strobe.wideWord ? {flashRdata, loReg}
                                     : {{(WORD_W-HALF_W){1'b0}}, flashRdata};

  // R2
  low_half_even_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.captureLo |-> ($past(flashAddr[0]) == 1'b0));

endmodule

// File: rtl/flash_fetch_adapter.sv
module flash_fetch_adapter
  import flash_adapter_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int HALF_W    = 16,
  parameter int MAX_BURST = 16,
  parameter int CNT_W     = $clog2(MAX_BURST + 1),
  parameter int IDX_W     = ADDR_W - 1,
  parameter int WORD_W    = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchReq,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              fetchHalf,
  input  logic              dataReq,
  input  logic [ADDR_W-1:0] dataAddr,
  input  logic              dataHalf,
  input  logic [CNT_W-1:0]  dataCount,
  output logic              flashRd,
  output logic [IDX_W-1:0]  flashAddr,
  input  logic [HALF_W-1:0] flashRdata,
  output logic              respReady,
  output logic              respIsData,
  output logic [WORD_W-1:0] respData
);

  adStrobe_t strobe;

  flash_adapter_ctrl #(
    .MAX_BURST(MAX_BURST),
    .CNT_W    (CNT_W)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .fetchReq  (fetchReq),
    .fetchHalf (fetchHalf),
    .dataReq   (dataReq),
    .dataHalf  (dataHalf),
    .dataCount (dataCount),
    .strobe    (strobe),
    .flashRd   (flashRd),
    .respReady (respReady),
    .respIsData(respIsData)
  );

  flash_adapter_datapath #(
    .ADDR_W(ADDR_W),
    .HALF_W(HALF_W),
    .IDX_W (IDX_W),
    .WORD_W(WORD_W)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .fetchAddr (fetchAddr),
    .fetchHalf (fetchHalf),
    .dataAddr  (dataAddr),
    .dataHalf  (dataHalf),
    .flashRdata(flashRdata),
    .flashAddr (flashAddr),
    .respData  (respData)
  );

endmodule

// File: tb/test_flash_fetch_adapter.sv
module test_flash_fetch_adapter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fetchReq = 1'b0;
  logic [15:0] fetchAddr = '0;
  logic        fetchHalf = 1'b0;
  logic        dataReq = 1'b0;
  logic [15:0] dataAddr = '0;
  logic        dataHalf = 1'b0;
  logic [4:0]  dataCount = '0;
  logic        flashRd;
  logic [14:0] flashAddr;
  logic [15:0] flashRdata = '0;
  logic        respReady;
  logic        respIsData;
  logic [31:0] respData;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  flash_fetch_adapter i_flash_fetch_adapter (
    .clk(clk), .rstN(rstN),
    .fetchReq(fetchReq), .fetchAddr(fetchAddr), .fetchHalf(fetchHalf),
    .dataReq(dataReq), .dataAddr(dataAddr), .dataHalf(dataHalf), .dataCount(dataCount),
    .flashRd(flashRd), .flashAddr(flashAddr), .flashRdata(flashRdata),
    .respReady(respReady), .respIsData(respIsData), .respData(respData)
  );

  function automatic logic [15:0] memVal(logic [14:0] idx);
    return 16'(32'(idx) * 32'h2B1D + 32'h0F3A);
  endfunction

  function automatic logic [31:0] wordAt(logic [15:0] a);
    logic [14:0] base = {a[15:2], 1'b0};
    return {memVal(base + 15'd1), memVal(base)};
  endfunction

  always_ff @(posedge clk) if (flashRd) flashRdata <= memVal(flashAddr);

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic waitReady(output int cyc, output int rds, output logic firstRd);
    cyc = 0; rds = 0; firstRd = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) firstRd = flashRd;
      if (flashRd) rds++;
      if (respReady) return;
    end
    cyc = -1;
  endtask

  task automatic testReset();
    check(respReady == 1'b0, "R1", "ready after reset", respReady, 0);
    check(flashRd == 1'b0, "R1", "read after reset", flashRd, 0);
    repeat (3) @(negedge clk);
    check(respReady == 1'b0 && flashRd == 1'b0, "R1", "quiet idle", {respReady, flashRd}, 0);
  endtask

  task automatic testFetch32(logic [15:0] a, string req);
    int c, r; logic f;
    fetchAddr = a; fetchHalf = 1'b0; fetchReq = 1'b1;
    waitReady(c, r, f);
    fetchReq = 1'b0;
    check(c == 3, req, "fetch32 ready cycle", c, 3);
    check(r == 2, "R2", "fetch32 reads", r, 2);
    check(respData == wordAt(a), req, "fetch32 data", respData, wordAt(a));
    check(respIsData == 1'b0, "R10", "fetch32 source", respIsData, 0);
    @(negedge clk);
    check(respReady == 1'b0, "R7", "fetch32 pulse width", respReady, 0);
  endtask

  task automatic testFetch16Chain();
    int c, r; logic f;
    fetchAddr = 16'h0207; fetchHalf = 1'b1; fetchReq = 1'b1;
    waitReady(c, r, f);
    check(c == 2, "R3", "fetch16 ready cycle", c, 2);
    check(r == 1, "R3", "fetch16 reads", r, 1);
    check(respData == {16'h0, memVal(15'h103)}, "R11", "fetch16 data", respData,
          {16'h0, memVal(15'h103)});
    fetchAddr = 16'h0208;
    waitReady(c, r, f);
    fetchReq = 1'b0;
    check(c == 3, "R9", "chained fetch ready cycle", c, 3);
    check(respData == {16'h0, memVal(15'h104)}, "R3", "chained fetch data", respData,
          {16'h0, memVal(15'h104)});
    fetchHalf = 1'b0;
    @(negedge clk);
  endtask

  task automatic testData32();
    int c, r; logic f;
    dataAddr = 16'h0300; dataHalf = 1'b0; dataCount = 5'd1; dataReq = 1'b1;
    waitReady(c, r, f);
    dataReq = 1'b0;
    check(c == 4, "R4", "data32 ready cycle", c, 4);
    check(f == 1'b0, "R4", "dead cycle read", f, 0);
    check(r == 2, "R4", "data32 reads", r, 2);
    check(respData == wordAt(16'h0300), "R4", "data32 data", respData, wordAt(16'h0300));
    check(respIsData == 1'b1, "R10", "data32 source", respIsData, 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic testData16();
    int c, r; logic f; int extra = 0;
    dataAddr = 16'h0302; dataHalf = 1'b1; dataCount = 5'd4; dataReq = 1'b1;
    waitReady(c, r, f);
    dataReq = 1'b0;
    check(c == 3, "R5", "data16 ready cycle", c, 3);
    check(f == 1'b0 && r == 1, "R5", "data16 dead+reads", {f, 8'(r)}, 1);
    check(respData == {16'h0, memVal(15'h181)}, "R5", "data16 data", respData,
          {16'h0, memVal(15'h181)});
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (respReady) extra++;
    end
    check(extra == 0, "R5", "count ignored for half read", extra, 0);
    dataHalf = 1'b0;
  endtask

  task automatic testBurst(logic [15:0] a, int n);
    int c, r; logic f;
    dataAddr = a; dataHalf = 1'b0; dataCount = 5'(n); dataReq = 1'b1;
    for (int k = 0; k < n; k++) begin
      waitReady(c, r, f);
      if (k == n - 1) dataReq = 1'b0;
      check(c == 4 && r == 2 && f == 1'b0, "R6", "burst word timing", {8'(c), 8'(r)}, 16'h0402);
      check(respData == wordAt(a + 16'(4 * k)), "R6", "burst word data", respData,
            wordAt(a + 16'(4 * k)));
    end
    c = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (respReady) c++;
    end
    check(c == 0, "R6", "no pulse after last word", c, 0);
  endtask

  task automatic testPriorityGap();
    int c, r; logic f;
    dataAddr = 16'h0500; dataHalf = 1'b0; dataCount = 5'd0; dataReq = 1'b1;
    fetchAddr = 16'h0600; fetchHalf = 1'b0; fetchReq = 1'b1;
    waitReady(c, r, f);
    dataReq = 1'b0;
    check(c == 4 && respIsData == 1'b1, "R8", "data served first", {8'(c), 7'd0, respIsData},
          16'h0401);
    check(respData == wordAt(16'h0500), "R8", "data word", respData, wordAt(16'h0500));
    waitReady(c, r, f);
    fetchReq = 1'b0;
    check(c == 5, "R9", "fetch after data gap", c, 5);
    check(respIsData == 1'b0 && respData == wordAt(16'h0600), "R10", "fetch after data",
          respData, wordAt(16'h0600));
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFetch32(16'h0100, "R2");
    testFetch32(16'h0103, "R11");
    testFetch16Chain();
    testData32();
    testData16();
    testBurst(16'h0400, 3);
    testBurst(16'h0800, 16);
    testPriorityGap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule